// File: doc/BRIEF.md
# Three-Button Game Pad Select Multiplexer

This block models the controller end of a three-button game pad that hangs off one parallel I/O port. The port controller writes bytes to the pad. One bit of each written byte is kept as a select level, and that level decides which half of the eight buttons the pad returns on its 7-bit active-low read bus. With select high the pad returns the four directions plus B and C. With select low it returns up, down, A and start, and it drives two identification bits low so that the host can tell that a pad is present.

Button levels come from asynchronous pad contacts. They pass through a synchronizer chain of parameterized depth before they reach the multiplexer. The select level is a plain register. The read value is formed combinationally from that register and the synchronized buttons, so a new select level shows on the bus in the cycle right after the write.

Top module: `pad_select_mux`

## Requirements
- R1: After reset the select level is low. With no button pressed the read bus shows 7'h33.
- R2: The select level takes the value of `wr_data[6]` on every clock edge at which `wr_stb` is 1. It keeps that value on every edge at which `wr_stb` is 0.
- R3: With select high, bits 0 to 5 of `rd_data` are the inverted levels of up, down, left, right, B and C, in that order, and bit 6 reads 1.
- R4: With select low, bit 0 is inverted up, bit 1 is inverted down, bits 2 and 3 read 0, bit 4 is inverted A, bit 5 is inverted start, and bit 6 reads 0.
- R5: Bits of `wr_data` other than bit 6 have no effect on the select level or on the read bus.
- R6: A change on a button input reaches `rd_data` exactly SYNC_STAGES clock edges after it is applied (default 2), and not earlier.
- R7: After a write that changes the select level, `rd_data` shows the new group in the cycle right after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_up | input | 1 | Up button, 1 = pressed |
| btn_down | input | 1 | Down button, 1 = pressed |
| btn_left | input | 1 | Left button, 1 = pressed |
| btn_right | input | 1 | Right button, 1 = pressed |
| btn_a | input | 1 | A button, 1 = pressed |
| btn_b | input | 1 | B button, 1 = pressed |
| btn_c | input | 1 | C button, 1 = pressed |
| btn_start | input | 1 | Start button, 1 = pressed |
| wr_stb | input | 1 | Port output write strobe |
| wr_data | input | WR_W | Port output byte; bit SEL_BIT sets the select level |
| rd_data | output | 7 | Active-low value returned to the port controller |

## Verification
The select register is the only state that matters here. If it is wrong, bit 6 of the read bus and the whole button grouping flip. The error is visible in the cycle after the faulty write edge. A wrong stage in the button synchronizer shows up as a button that appears one edge too early or too late, or as a button that appears on the wrong bit. Each check is made at a fixed edge count after its stimulus, so any off-by-one latency is caught.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;
   localparam int BTN_N = 8;
   localparam int RD_W  = 7;

   typedef struct packed {
      logic start;
      logic c;
      logic b;
      logic a;
      logic right;
      logic left;
      logic down;
      logic up;
   } btn_t;

   localparam logic [RD_W-1:0] RD_IDLE_LOW = 7'h33;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pad_sel_latch.sv
module pad_sel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sel_in,
   output logic sel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= 1'b0;
      else if (load) sel_q <= sel_in;
   end
endmodule

// File: rtl/pad_group_mux.sv
module pad_group_mux
   import pad_mux_pkg::*;
(
   input  logic            sel,
   input  btn_t            btn,
   output logic [RD_W-1:0] rd
);
   always_comb begin
      if (sel) begin
         rd = {1'b1, ~btn.c, ~btn.b, ~btn.right, ~btn.left, ~btn.down, ~btn.up};
      end else begin
         rd = {1'b0, ~btn.start, ~btn.a, 2'b00, ~btn.down, ~btn.up};
      end
   end
endmodule

// File: rtl/pad_select_mux.sv
module pad_select_mux
   import pad_mux_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WR_W        = 8,
   parameter int SEL_BIT     = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            btn_up,
   input  logic            btn_down,
   input  logic            btn_left,
   input  logic            btn_right,
   input  logic            btn_a,
   input  logic            btn_b,
   input  logic            btn_c,
   input  logic            btn_start,
   input  logic            wr_stb,
   input  logic [WR_W-1:0] wr_data,
   output logic [RD_W-1:0] rd_data
);
   generate
      if (SEL_BIT < 0 || SEL_BIT >= WR_W) begin : g_bad_sel
         $error("SEL_BIT must index inside wr_data");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..8");
      end
   endgenerate

   btn_t raw_btn;
   btn_t syn_btn;
   logic th_q;
   logic unused_wr;

   assign raw_btn = '{start: btn_start, c: btn_c, b: btn_b, a: btn_a,
                      right: btn_right, left: btn_left, down: btn_down, up: btn_up};
   assign unused_wr = ^wr_data;

   pad_sync #(.WIDTH(BTN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_btn),
      .dout (syn_btn)
   );

   pad_sel_latch u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_stb),
      .sel_in(wr_data[SEL_BIT]),
      .sel_q (th_q)
   );

   pad_group_mux u_mux (
      .sel(th_q),
      .btn(syn_btn),
      .rd (rd_data)
   );
endmodule

// File: rtl/pad_select_mux_chk.sv
module pad_select_mux_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       sel_in,
   input logic       th,
   input logic [6:0] rd_data
);
   assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !th);
   assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> th == $past(sel_in));
   assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(th));
   assert_high_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
      th |-> rd_data[6]);
   assert_low_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !th |-> (rd_data[6] == 1'b0 && rd_data[3:2] == 2'b00));
endmodule

bind pad_select_mux pad_select_mux_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_stb (wr_stb),
   .sel_in (wr_data[SEL_BIT]),
   .th     (th_q),
   .rd_data(rd_data)
);

// File: tb/pad_select_mux_bench.sv
`timescale 1ns/1ps
module pad_select_mux_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bv = 8'h00;   // {start,c,b,a,right,left,down,up}
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [6:0] rd_data;
   int         n_chk = 0;
   int         n_bad = 0;
   logic       ref_th = 1'b0;
   logic       done = 1'b0;

   always #2 clk = ~clk;

   pad_select_mux u_pad_select_mux (
      .clk(clk), .rst_n(rst_n),
      .btn_up(bv[0]), .btn_down(bv[1]), .btn_left(bv[2]), .btn_right(bv[3]),
      .btn_a(bv[4]), .btn_b(bv[5]), .btn_c(bv[6]), .btn_start(bv[7]),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
   );

   function automatic logic [6:0] model(input logic th, input logic [7:0] b);
      if (th) return {1'b1, ~b[6], ~b[5], ~b[3], ~b[2], ~b[1], ~b[0]};
      else    return {1'b0, ~b[7], ~b[4], 2'b00, ~b[1], ~b[0]};
   endfunction

   task automatic check(input string req, input logic [6:0] exp);
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(posedge clk);
      @(negedge clk); wr_stb = 1'b0; wr_data = 8'h00;
      ref_th = d[6];
   endtask

   task automatic set_btn(input logic [7:0] v);
      @(negedge clk); bv = v;
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_R1();
      check("R1", 7'h33);
   endtask

   task automatic t_high_group_R3();
      do_write(8'h40);
      for (int i = 0; i < 8; i++) begin
         set_btn(8'h01 << i);
         check("R3", model(1'b1, bv));
      end
      set_btn(8'hFF); check("R3", 7'h40);
      set_btn(8'h00); check("R3", 7'h7F);
   endtask

   task automatic t_low_group_R4();
      do_write(8'h00);
      for (int i = 0; i < 8; i++) begin
         set_btn(8'h01 << i);
         check("R4", model(1'b0, bv));
      end
      set_btn(8'hFF); check("R4", 7'h00);
      set_btn(8'h00); check("R4", 7'h33);
   endtask

   task automatic t_write_bits_R5();
      set_btn(8'h5A);
      do_write(8'hBF); check("R5", model(1'b0, bv));
      do_write(8'h40); check("R5", model(1'b1, bv));
      do_write(8'hFF); check("R5", model(1'b1, bv));
      do_write(8'h80); check("R5", model(1'b0, bv));
   endtask

   task automatic t_hold_R2();
      do_write(8'h40);
      repeat (5) @(negedge clk);
      check("R2", model(1'b1, bv));
      do_write(8'h00);
      repeat (5) @(negedge clk);
      check("R2", model(1'b0, bv));
   endtask

   task automatic t_select_latency_R7();
      set_btn(8'h24);
      do_write(8'h40); check("R7", model(1'b1, bv));
      do_write(8'h00); check("R7", model(1'b0, bv));
   endtask

   task automatic t_btn_latency_R6();
      logic [7:0] old_v;
      do_write(8'h40);
      set_btn(8'h00);
      old_v = bv;
      @(negedge clk); bv = 8'h6F;
      @(posedge clk); @(negedge clk);
      check("R6", model(1'b1, old_v));
      @(posedge clk); @(negedge clk);
      check("R6", model(1'b1, bv));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_R1();
      t_high_group_R3();
      t_low_group_R4();
      t_write_bits_R5();
      t_hold_R2();
      t_select_latency_R7();
      t_btn_latency_R6();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule